// File: doc/BRIEF.md
# Flash Command Snooper with Bit Striping

This engine sits on the transmit path of a serial flash controller. It sits between a transmit byte queue and one or more parallel byte lanes. Each chip-select transaction starts with a byte that the engine reads as a flash opcode. The opcode sets how many address, mode and dummy bytes follow it. The engine sends those bytes unchanged, and each one goes out identically on every lane. Only lane 0's returned byte is kept. Once that count runs out, the engine switches to striping for the rest of the transaction. In striping, a group of bytes (one per lane) is popped in a single step, and its bits are spread across the lanes. Returned bits are gathered back into bytes in the same order.

A flush starts on a pulse of `flush_i`. The engine then runs transfers, called beats, until the queue holds fewer bytes than the next beat needs. At that point the flush ends. An underflow event is raised at the end of the flush unless linear mode is active. An opcode that is not recognised turns striping off until chip-select is released. Releasing chip-select returns the engine to opcode watching. Queue storage lives outside the block: the transmit side shows its level and its head bytes, and the receive side shows a full flag.

Top module: `snoop_stripe_engine`

## Requirements
- R1: After reset, and in every cycle after `cs_active_i` is low, the next byte popped is treated as an opcode and is sent as a non-striped beat.
- R2: The opcodes 0x03, 0x02, 0xA2 and 0x32 are each followed by exactly three non-striped beats. Striping starts at the beat after those three.
- R3: The opcodes 0x0B, 0x3B, 0x6B and 0xBB are followed by four non-striped beats, and 0xEB by six. Striping starts after them.
- R4: Any other opcode keeps every later beat non-striped until `cs_active_i` drops.
- R5: A non-striped beat pops one byte and presents it on every lane. It then pushes exactly one byte, lane 0's returned byte, into the receive queue.
- R6: A striping beat pops LANES bytes in one cycle (`tx_pop_cnt_o` = LANES). Number the popped bits as a stream: stream bit 8*i+b is bit b of the i-th byte. Lane l, bit j then carries stream bit j*LANES+l. Byte i is taken from `tx_data_i[8*i+7:8*i]`, and lane l is on bits `[8*l+7:8*l]` of the lane buses.
- R7: After a striping beat, the returned lane bits go through the inverse mapping. The LANES bytes that result are pushed in stream order, byte 0 first.
- R8: When a byte is due for the receive queue while `rx_full_i` is high, that byte is dropped. `overflow_o` pulses for one cycle and `rx_push_o` stays low.
- R9: When the queue level is below what the next beat needs, nothing is popped and the flush ends. `underflow_o` pulses once unless `linear_mode_i` is high. Leftover bytes stay queued.
- R10: A beat completes only when every lane has acknowledged. Each lane's request drops in the cycle after its own acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Pulse that starts draining the transmit queue |
| cs_active_i | input | 1 | High while any chip-select is asserted |
| linear_mode_i | input | 1 | Suppresses the underflow event |
| tx_level_i | input | LEVEL_W | Number of bytes held in the transmit queue |
| tx_data_i | input | 8*LANES | Head bytes of the transmit queue, oldest in the low byte |
| tx_pop_o | output | 1 | Removes `tx_pop_cnt_o` bytes from the transmit queue |
| tx_pop_cnt_o | output | clog2(LANES+1) | Number of bytes removed on a pop |
| lane_req_o | output | LANES | Per-lane byte exchange request |
| lane_tx_o | output | 8*LANES | Per-lane byte to send |
| lane_ack_i | input | LANES | Per-lane exchange acknowledge |
| lane_rx_i | input | 8*LANES | Per-lane returned byte, valid with its acknowledge |
| rx_full_i | input | 1 | Receive queue is full |
| rx_push_o | output | 1 | Writes `rx_data_o` into the receive queue |
| rx_data_o | output | 8 | Received byte |
| underflow_o | output | 1 | Flush ended on an empty queue |
| overflow_o | output | 1 | A received byte was dropped |

## Verification
The countdown that follows each opcode can be wrong by a single step. That error first shows as one beat whose lane buses carry duplicated bytes where interleaved bits were expected, or the reverse. The same beat also pushes one receive byte instead of LANES. So the stimulus streams include enough payload to cross the switch point of every opcode group. Each beat's lane bytes and pushes are compared at that exact beat index. A chip-select release that fails to reset the tracker shows up at the first beat of the next transaction. A wrong permutation shows up on any striping beat that carries an asymmetric bit pattern.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;

  localparam logic [7:0] SNP_CHECK  = 8'hFF;
  localparam logic [7:0] SNP_NONE   = 8'hFE;
  localparam logic [7:0] SNP_STRIPE = 8'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER, ST_PUSH} beat_state_e;

  // non-striped beats still to come after an opcode
  function automatic logic [7:0] opcode_count(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: return 8'd3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 8'd4;
      8'hEB:                      return 8'd6;
      default:                    return SNP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/bit_striper.sv
`timescale 1ns/1ps
module bit_striper #(
  parameter int LANES   = 2,
  parameter bit INVERSE = 1'b0
) (
  input  logic [LANES*8-1:0] data_i,
  output logic [LANES*8-1:0] data_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar j = 0; j < 8; j++) begin : g_bit
      if (INVERSE) begin : g_gather
        assign data_o[j*LANES+l] = data_i[l*8+j];
      end else begin : g_spread
        assign data_o[l*8+j] = data_i[j*LANES+l];
      end
    end
  end

endmodule

// File: rtl/snoop_tracker.sv
`timescale 1ns/1ps
module snoop_tracker
  import snoop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_active_i,
  input  logic       beat_done_i,
  input  logic [7:0] opcode_i,
  output logic       striping_o
);

  logic [7:0] snp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snp_q <= SNP_CHECK;
    end else if (!cs_active_i) begin
      snp_q <= SNP_CHECK;
    end else if (beat_done_i) begin
      if (snp_q == SNP_CHECK) begin
        snp_q <= opcode_count(opcode_i);
      end else if (snp_q != SNP_NONE && snp_q != SNP_STRIPE) begin
        snp_q <= snp_q - 8'd1;
      end
    end
  end

  assign striping_o = (snp_q == SNP_STRIPE);

  assert_cs_rearm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active_i |=> snp_q == SNP_CHECK);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_active_i && beat_done_i && snp_q != SNP_CHECK && snp_q != SNP_NONE && snp_q != SNP_STRIPE)
    |=> snp_q == $past(snp_q) - 8'd1);

  assert_deep_dummy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_active_i && beat_done_i && snp_q == SNP_CHECK && opcode_i == 8'hEB) |=> snp_q == 8'd6);

  assert_none_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_active_i && snp_q == SNP_NONE) |=> snp_q == SNP_NONE);

  assert_stripe_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_active_i && snp_q == SNP_STRIPE) |=> snp_q == SNP_STRIPE);

endmodule

// File: rtl/snoop_stripe_engine.sv
`timescale 1ns/1ps
module snoop_stripe_engine
  import snoop_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int LEVEL_W = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         cs_active_i,
  input  logic                         linear_mode_i,
  input  logic [LEVEL_W-1:0]           tx_level_i,
  input  logic [LANES*8-1:0]           tx_data_i,
  output logic                         tx_pop_o,
  output logic [$clog2(LANES+1)-1:0]   tx_pop_cnt_o,
  output logic [LANES-1:0]             lane_req_o,
  output logic [LANES*8-1:0]           lane_tx_o,
  input  logic [LANES-1:0]             lane_ack_i,
  input  logic [LANES*8-1:0]           lane_rx_i,
  input  logic                         rx_full_i,
  output logic                         rx_push_o,
  output logic [7:0]                   rx_data_o,
  output logic                         underflow_o,
  output logic                         overflow_o
);

  localparam int BUS_W = LANES * 8;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  beat_state_e      state_q;
  logic [BUS_W-1:0] lane_tx_q, lane_rx_q;
  logic [LANES-1:0] done_q;
  logic             beat_stripe_q;
  logic [7:0]       opcode_q;
  logic [IDX_W-1:0] push_idx_q;

  logic             striping, have_bytes, beat_done, all_done, last_push;
  logic [CNT_W-1:0] need;
  logic [LANES-1:0] ack_hit;
  logic [BUS_W-1:0] tx_striped, rx_unstriped;
  logic [7:0]       push_byte;

  bit_striper #(.LANES(LANES), .INVERSE(1'b0)) u_tx_spread (
    .data_i(tx_data_i),
    .data_o(tx_striped)
  );

  bit_striper #(.LANES(LANES), .INVERSE(1'b1)) u_rx_gather (
    .data_i(lane_rx_q),
    .data_o(rx_unstriped)
  );

  snoop_tracker u_snoop (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_active_i(cs_active_i),
    .beat_done_i(beat_done),
    .opcode_i   (opcode_q),
    .striping_o (striping)
  );

  assign need       = striping ? CNT_W'(LANES) : CNT_W'(1);
  assign have_bytes = tx_level_i >= LEVEL_W'(need);
  assign ack_hit    = lane_ack_i & lane_req_o;
  assign all_done   = &(done_q | ack_hit);
  assign beat_done  = (state_q == ST_XFER) && all_done;
  assign push_byte  = beat_stripe_q ? rx_unstriped[int'(push_idx_q)*8 +: 8] : lane_rx_q[7:0];
  assign last_push  = !beat_stripe_q || (push_idx_q == IDX_W'(LANES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      lane_tx_q     <= '0;
      lane_rx_q     <= '0;
      done_q        <= '0;
      beat_stripe_q <= 1'b0;
      opcode_q      <= '0;
      push_idx_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (flush_i) state_q <= ST_FETCH;
        ST_FETCH: begin
          if (have_bytes) begin
            lane_tx_q     <= striping ? tx_striped : {LANES{tx_data_i[7:0]}};
            beat_stripe_q <= striping;
            opcode_q      <= tx_data_i[7:0];
            done_q        <= '0;
            state_q       <= ST_XFER;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_XFER: begin
          for (int l = 0; l < LANES; l++) begin
            if (ack_hit[l]) begin
              lane_rx_q[l*8 +: 8] <= lane_rx_i[l*8 +: 8];
              done_q[l]           <= 1'b1;
            end
          end
          if (all_done) begin
            push_idx_q <= '0;
            state_q    <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (last_push) state_q <= ST_FETCH;
          else           push_idx_q <= push_idx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_pop_o     = (state_q == ST_FETCH) && have_bytes;
  assign tx_pop_cnt_o = need;
  assign underflow_o  = (state_q == ST_FETCH) && !have_bytes && !linear_mode_i;
  assign lane_req_o   = (state_q == ST_XFER) ? ~done_q : '0;
  assign lane_tx_o    = lane_tx_q;
  assign rx_push_o    = (state_q == ST_PUSH) && !rx_full_i;
  assign overflow_o   = (state_q == ST_PUSH) && rx_full_i;
  assign rx_data_o    = push_byte;

  assert_pop_backed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> tx_level_i >= LEVEL_W'(tx_pop_cnt_o));

  assert_pop_size_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> (tx_pop_cnt_o == CNT_W'(1) || tx_pop_cnt_o == CNT_W'(LANES)));

  assert_no_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |-> !rx_push_o);

  assert_linear_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    linear_mode_i |-> !underflow_o);

  assert_req_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_req_o[0] && lane_ack_i[0]) |=> !lane_req_o[0]);

  assert_no_pop_in_xfer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_req_o != '0) |-> !tx_pop_o && !rx_push_o);

endmodule

// File: tb/snoop_stripe_engine_tb.sv
`timescale 1ns/1ps
module snoop_stripe_engine_tb;

  localparam int LANES = 2;
  localparam int LW    = 8;
  localparam logic [7:0] K0 = 8'h5A;
  localparam logic [7:0] K1 = 8'hC3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, cs = 1'b0, linear = 1'b0, rx_full = 1'b0;
  logic [LW-1:0] tx_level;
  logic [15:0] tx_data;
  logic        tx_pop;
  logic [1:0]  tx_pop_cnt;
  logic [1:0]  lreq, lack;
  logic [15:0] ltx, lrx;
  logic        rx_push, underflow, overflow;
  logic [7:0]  rx_data;

  always #10 clk = ~clk;

  snoop_stripe_engine #(.LANES(LANES), .LEVEL_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .cs_active_i(cs),
    .linear_mode_i(linear), .tx_level_i(tx_level), .tx_data_i(tx_data),
    .tx_pop_o(tx_pop), .tx_pop_cnt_o(tx_pop_cnt), .lane_req_o(lreq),
    .lane_tx_o(ltx), .lane_ack_i(lack), .lane_rx_i(lrx), .rx_full_i(rx_full),
    .rx_push_o(rx_push), .rx_data_o(rx_data), .underflow_o(underflow),
    .overflow_o(overflow)
  );

  // transmit queue model
  logic [7:0] tx_mem [256];
  logic [7:0] wr_p = 8'd0;
  logic [7:0] rd_p;
  assign tx_level = wr_p - rd_p;
  assign tx_data  = {tx_mem[rd_p + 8'd1], tx_mem[rd_p]};
  always @(posedge clk) begin
    if (!rst_n)      rd_p <= 8'd0;
    else if (tx_pop) rd_p <= rd_p + 8'(tx_pop_cnt);
  end

  // lane responders: lane 0 answers at once, lane 1 after two cycles
  logic [3:0] wc1;
  assign lack[0] = lreq[0];
  assign lack[1] = lreq[1] && (wc1 >= 4'd2);
  assign lrx     = {ltx[15:8] ^ K1, ltx[7:0] ^ K0};
  always @(posedge clk) begin
    if (!rst_n) wc1 <= 4'd0;
    else        wc1 <= (lreq[1] && !lack[1]) ? wc1 + 4'd1 : 4'd0;
  end

  // monitors
  logic [7:0] lane_log0 [256];
  logic [7:0] lane_log1 [256];
  logic [7:0] rx_log    [256];
  int lane_n0, lane_n1, rx_n, uf_n, ov_n;
  always @(posedge clk) begin
    if (!rst_n) begin
      lane_n0 <= 0; lane_n1 <= 0; rx_n <= 0; uf_n <= 0; ov_n <= 0;
    end else begin
      if (lreq[0] && lack[0]) begin lane_log0[lane_n0 % 256] <= ltx[7:0];  lane_n0 <= lane_n0 + 1; end
      if (lreq[1] && lack[1]) begin lane_log1[lane_n1 % 256] <= ltx[15:8]; lane_n1 <= lane_n1 + 1; end
      if (rx_push) begin rx_log[rx_n % 256] <= rx_data; rx_n <= rx_n + 1; end
      if (underflow) uf_n <= uf_n + 1;
      if (overflow)  ov_n <= ov_n + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] stim [32];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stripe2(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] s, r;
    s = {b, a};
    r = '0;
    for (int k = 0; k < 16; k++) r[(k % 2) * 8 + k / 2] = s[k];
    return r;
  endfunction

  function automatic logic [15:0] unstripe2(input logic [15:0] r);
    logic [15:0] s;
    for (int k = 0; k < 16; k++) s[k] = r[(k % 2) * 8 + k / 2];
    return s;
  endfunction

  function automatic int exp_count(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: return 3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 4;
      8'hEB:                      return 6;
      default:                    return 254;
    endcase
  endfunction

  task automatic push_bytes(input int n);
    for (int k = 0; k < n; k++) begin
      tx_mem[wr_p] = stim[k];
      wr_p = wr_p + 8'd1;
    end
  endtask

  task automatic do_flush();
    int guard;
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    guard = 0;
    while (!underflow && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 500) chk(0, 1, "R9 flush end");
    @(negedge clk);
  endtask

  task automatic check_stream(input int n, input int b0, input int b1, input int rb, input string tag);
    int st, i, beats, pushes;
    logic [15:0] ln, er;
    st = 255; i = 0; beats = 0; pushes = 0;
    while (1) begin
      if (st == 0) begin
        if (n - i < 2) break;
        ln = stripe2(stim[i], stim[i+1]);
        i += 2;
        chk({lane_log1[b1+beats], lane_log0[b0+beats]}, ln, "R6");
        er = unstripe2(ln ^ {K1, K0});
        chk(rx_log[rb+pushes], er[7:0], "R7");
        chk(rx_log[rb+pushes+1], er[15:8], "R7");
        pushes += 2;
      end else begin
        if (i >= n) break;
        ln = {stim[i], stim[i]};
        chk({lane_log1[b1+beats], lane_log0[b0+beats]}, ln, (beats == 0) ? "R1" : "R5");
        chk(rx_log[rb+pushes], stim[i] ^ K0, "R5");
        pushes++;
        if (st == 255)      st = exp_count(stim[i]);
        else if (st != 254) st--;
        i++;
      end
      beats++;
    end
    chk(lane_n0 - b0, beats, tag);
    chk(lane_n1 - b1, beats, "R10");
    chk(rx_n - rb, pushes, "R7");
  endtask

  task automatic run_txn(input int n, input string tag);
    int b0, b1, rb;
    @(negedge clk) cs = 1'b1;
    b0 = lane_n0; b1 = lane_n1; rb = rx_n;
    push_bytes(n);
    do_flush();
    check_stream(n, b0, b1, rb, tag);
    @(negedge clk) cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tx_pop, 0, "R1 reset pop");
    chk(lreq, 0, "R10 reset req");
    chk(rx_push, 0, "R1 reset push");
    chk(underflow, 0, "R9 reset underflow");
  endtask

  task automatic t_read_group();
    stim[0] = 8'h03; stim[1] = 8'h11; stim[2] = 8'h22; stim[3] = 8'h33;
    stim[4] = 8'hA5; stim[5] = 8'h3C; stim[6] = 8'hF0; stim[7] = 8'h0F;
    run_txn(8, "R2");
    stim[0] = 8'h32; stim[1] = 8'h01; stim[2] = 8'h80; stim[3] = 8'h7E;
    stim[4] = 8'h96; stim[5] = 8'h1E;
    run_txn(6, "R2");
  endtask

  task automatic t_dummy_group();
    stim[0] = 8'h3B;
    for (int k = 1; k < 9; k++) stim[k] = 8'(k * 37 + 5);
    run_txn(9, "R3");
    stim[0] = 8'hEB;
    for (int k = 1; k < 11; k++) stim[k] = 8'(k * 29 + 3);
    run_txn(11, "R3");
  endtask

  task automatic t_unknown();
    stim[0] = 8'h9F;
    for (int k = 1; k < 8; k++) stim[k] = 8'(k * 51 + 9);
    run_txn(8, "R4");
  endtask

  task automatic t_cs_rearm();
    stim[0] = 8'h02; stim[1] = 8'h10; stim[2] = 8'h20; stim[3] = 8'h30;
    stim[4] = 8'hC6; stim[5] = 8'h39;
    run_txn(6, "R2");
    // striping reached and cs dropped: new first byte must be an opcode again
    stim[0] = 8'h05; stim[1] = 8'hE1; stim[2] = 8'h4B; stim[3] = 8'hD2;
    run_txn(4, "R1");
  endtask

  task automatic t_underflow();
    int u0, b0, b1;
    @(negedge clk) cs = 1'b1;
    stim[0] = 8'h03; stim[1] = 8'h01; stim[2] = 8'h02; stim[3] = 8'h03; stim[4] = 8'h44;
    u0 = uf_n; b0 = lane_n0;
    push_bytes(5);
    do_flush();
    chk(uf_n - u0, 1, "R9 single underflow");
    chk(tx_level, 1, "R9 leftover kept");
    chk(lane_n0 - b0, 4, "R9 beats before underflow");
    // complete the pair; striping persists across flushes while cs holds
    stim[0] = 8'h55;
    b0 = lane_n0; b1 = lane_n1;
    push_bytes(1);
    do_flush();
    chk(tx_level, 0, "R6 pair popped");
    chk(lane_n0 - b0, 1, "R6 one beat");
    chk({lane_log1[b1], lane_log0[b0]}, stripe2(8'h44, 8'h55), "R6 interleave");
    @(negedge clk) cs = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_linear();
    int u0, b0;
    @(negedge clk) begin cs = 1'b1; linear = 1'b1; end
    stim[0] = 8'h9F; stim[1] = 8'h6D;
    u0 = uf_n; b0 = lane_n0;
    push_bytes(2);
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    repeat (40) @(negedge clk);
    chk(uf_n - u0, 0, "R9 linear no underflow");
    chk(tx_level, 0, "R9 linear drained");
    chk(lane_n0 - b0, 2, "R5 linear beats");
    @(negedge clk) begin cs = 1'b0; linear = 1'b0; end
    @(negedge clk);
  endtask

  task automatic t_overflow();
    int o0, r0;
    @(negedge clk) begin cs = 1'b1; rx_full = 1'b1; end
    stim[0] = 8'h9F; stim[1] = 8'h12; stim[2] = 8'h34;
    o0 = ov_n; r0 = rx_n;
    push_bytes(3);
    do_flush();
    chk(ov_n - o0, 3, "R8 overflow count");
    chk(rx_n - r0, 0, "R8 nothing pushed");
    @(negedge clk) begin cs = 1'b0; rx_full = 1'b0; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_group();
    t_dummy_group();
    t_unknown();
    t_cs_rearm();
    t_underflow();
    t_linear();
    t_overflow();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule